// File: doc/BRIEF.md
# Paged Read With Per-Page CRC

This block answers a read command on a 128-byte one-time-programmable array that is split into four pages of 32 bytes. A start pulse loads a 7-bit starting address. After that, each byte-request strobe returns one byte on the output, one cycle after the strobe. When the last byte of a page has been delivered, the next request returns a CRC-8 byte instead of data, so each page reads as 33 bytes. That CRC covers only the bytes delivered from that page. Reading then carries on at the first byte of the following page, with the CRC accumulator started again from zero.

When the CRC of the final page has been returned, every later request yields 0xFF until a bus reset. A bus reset can abort the stream at any point and puts the block back in idle. The array sits inside the block as a register file with a synchronous read. It is filled through a programming port that can only clear bits, because a programmed byte is the AND of the stored value and the written value. Bit-level time slots and the electrical layer are handled elsewhere.

Top module: `paged_crc_reader`

## Requirements
- R1: After rst_n is released, out_valid and crc_valid are 0 until a request is served.
- R2: A request made while a stream is active produces exactly one output byte, with out_valid high, in the cycle after the request. After a start at address A, the data bytes come out in order from A, and each one equals the array content at its address.
- R3: After the byte at in-page offset 31 (address bits [4:0] all ones) is delivered, the next request returns a CRC byte with crc_valid high. crc_valid is never high in two consecutive output cycles.
- R4: The CRC is CRC-8 with polynomial x^8+x^5+x^4+1, shifted in least significant bit first (reflected constant 0x8C), starting from 0x00. The first page's CRC covers the bytes from the starting address to the end of that page.
- R5: After a page's CRC, the next request returns the first byte of the next page. That page's CRC covers all 32 of its bytes, starting again from 0x00.
- R6: After the CRC of the last page (address 127), every further request returns 0xFF with crc_valid low, until a bus reset or a new start.
- R7: A bus_rst pulse aborts the stream at any point. In the cycle after it, out_valid is 0, and later requests give no output until a new start.
- R8: A request while idle (after reset or bus_rst, before any start) is ignored and gives no out_valid pulse.
- R9: Programming address P with value V makes the stored byte the AND of its previous value and V. Bytes that were never programmed read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears the array to all ones |
| bus_rst | input | 1 | Aborts any stream and returns to idle |
| start | input | 1 | Begins a read stream at start_addr |
| start_addr | input | 7 | Starting byte address |
| req | input | 1 | Byte-request strobe |
| prog_en | input | 1 | Program strobe for the array |
| prog_addr | input | 7 | Address to program |
| prog_data | input | 8 | Value ANDed into the addressed byte |
| dout | output | 8 | Delivered byte |
| out_valid | output | 1 | dout holds a byte served for the previous request |
| crc_valid | output | 1 | dout holds a page CRC |

## Verification
The hardest case to reach is the move from the last page's CRC into the all-ones tail, together with a start whose first page is partial. The stimulus starts at address 127 so that a single data byte is followed at once by the final CRC and then the tail. A second run starts in the middle of a page and is aborted by a bus reset while the stream is still going. Requests come both back to back and spaced apart, so the address step and the page-end detection are exercised at different request rates.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC,
        ST_TAIL
    } pcr_state_e;

    function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] data_in);
        logic [7:0] c;
        logic       fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data_in[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/pcr_otp_array.sv
module pcr_otp_array #(
    parameter int BYTES  = 128,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] mem_q [BYTES];

    // Programming can only clear bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'hFF;
        end else if (prog_en) begin
            mem_q[prog_addr] <= mem_q[prog_addr] & prog_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= 8'hFF;
        else        rd_data <= mem_q[rd_addr];
    end
endmodule

// File: rtl/pcr_crc8_step.sv
module pcr_crc8_step (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    assign crc_out = pcr_pkg::crc8_byte(crc_in, data_in);
endmodule

// File: rtl/paged_crc_reader.sv
module paged_crc_reader #(
    parameter int PAGE_BYTES = 32,
    parameter int NUM_PAGES  = 4,
    parameter int ADDR_W     = $clog2(PAGE_BYTES * NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              req,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    output logic [7:0]        dout,
    output logic              out_valid,
    output logic              crc_valid
);
    import pcr_pkg::*;

    localparam int TOTAL_BYTES = PAGE_BYTES * NUM_PAGES;
    localparam int OFF_W       = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TOTAL_BYTES - 1);

    typedef struct packed {
        pcr_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        crc;
        logic [7:0]        dout;
        logic              out_valid;
        logic              crc_valid;
    } pcr_regs_t;

    pcr_regs_t r_q, r_d;
    logic [7:0] rd_data;
    logic [7:0] crc_next;
    logic       page_end;

    pcr_otp_array #(.BYTES(TOTAL_BYTES), .ADDR_W(ADDR_W)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_addr   (r_d.addr),
        .rd_data   (rd_data)
    );

    pcr_crc8_step crc_i (
        .crc_in  (r_q.crc),
        .data_in (rd_data),
        .crc_out (crc_next)
    );

    assign page_end = (r_q.addr[OFF_W-1:0] == {OFF_W{1'b1}});

    always_comb begin
        r_d           = r_q;
        r_d.out_valid = 1'b0;
        r_d.crc_valid = 1'b0;
        if (bus_rst) begin
            r_d.st  = ST_IDLE;
            r_d.crc = 8'h00;
        end else if (start) begin
            r_d.st   = ST_DATA;
            r_d.addr = start_addr;
            r_d.crc  = 8'h00;
        end else if (req) begin
            case (r_q.st)
                ST_DATA: begin
                    r_d.dout      = rd_data;
                    r_d.out_valid = 1'b1;
                    r_d.crc       = crc_next;
                    if (page_end) r_d.st   = ST_CRC;
                    else          r_d.addr = r_q.addr + 1'b1;
                end
                ST_CRC: begin
                    r_d.dout      = r_q.crc;
                    r_d.out_valid = 1'b1;
                    r_d.crc_valid = 1'b1;
                    r_d.crc       = 8'h00;
                    if (r_q.addr == LAST_ADDR) begin
                        r_d.st = ST_TAIL;
                    end else begin
                        r_d.st   = ST_DATA;
                        r_d.addr = r_q.addr + 1'b1;
                    end
                end
                ST_TAIL: begin
                    r_d.dout      = 8'hFF;
                    r_d.out_valid = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.addr      <= '0;
            r_q.crc       <= 8'h00;
            r_q.dout      <= 8'h00;
            r_q.out_valid <= 1'b0;
            r_q.crc_valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout      = r_q.dout;
    assign out_valid = r_q.out_valid;
    assign crc_valid = r_q.crc_valid;
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_rst,
    input logic start,
    input logic req,
    input logic out_valid,
    input logic crc_valid
);
    logic active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       active_q <= 1'b0;
        else if (bus_rst) active_q <= 1'b0;
        else if (start)   active_q <= 1'b1;
    end

    // R2: an output byte only ever answers a request
    p_valid_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req));

    // R3: a CRC byte is always a valid output byte
    p_crc_is_output_r3: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |-> out_valid);

    // R3: two CRC bytes never come out back to back
    p_crc_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |=> !crc_valid);

    // R7: a bus reset silences the next cycle
    p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !out_valid);

    // R8: requests while idle are ignored
    p_idle_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !start && !bus_rst && req) |=> !out_valid);
endmodule

bind paged_crc_reader pcr_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst   (bus_rst),
    .start     (start),
    .req       (req),
    .out_valid (out_valid),
    .crc_valid (crc_valid)
);

// File: tb/paged_crc_reader_tb.sv
module paged_crc_reader_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       start = 1'b0;
    logic [6:0] start_addr = '0;
    logic       req = 1'b0;
    logic       prog_en = 1'b0;
    logic [6:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [7:0] dout;
    logic       out_valid;
    logic       crc_valid;

    int total = 0;
    int bad = 0;
    int unexp = 0;
    bit finished = 1'b0;

    logic [7:0] model [128];
    logic [7:0] q_d [$];
    logic       q_c [$];
    string      q_t [$];

    int         m_addr;
    logic [7:0] m_crc;
    bit         m_crc_due;
    bit         m_tail;

    always #5 clk = ~clk;

    paged_crc_reader dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .start(start),
        .start_addr(start_addr), .req(req), .prog_en(prog_en),
        .prog_addr(prog_addr), .prog_data(prog_data), .dout(dout),
        .out_valid(out_valid), .crc_valid(crc_valid)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c = c_in;
        for (int i = 0; i < 8; i++) begin
            if ((c[0] ^ d[i]) == 1'b1) c = (c >> 1) ^ 8'h8C;
            else                       c = c >> 1;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (q_d.size() == 0) begin
                unexp++;
                total++;
                bad++;
                $display("FAIL R8 unexpected output: actual=%0h expected=none", dout);
            end else begin
                logic [7:0] ed;
                logic       ec;
                string      et;
                ed = q_d.pop_front();
                ec = q_c.pop_front();
                et = q_t.pop_front();
                check(dout == ed, et, "byte", dout, ed);
                check(crc_valid == ec, et, "crc flag", crc_valid, ec);
            end
        end
    end

    task automatic prog(input int a, input logic [7:0] v);
        @(negedge clk);
        prog_en = 1'b1; prog_addr = 7'(a); prog_data = v;
        model[a] = model[a] & v;
        @(negedge clk);
        prog_en = 1'b0;
    endtask

    task automatic do_start(input int a);
        @(negedge clk);
        start = 1'b1; start_addr = 7'(a);
        m_addr = a; m_crc = 8'h00; m_crc_due = 1'b0; m_tail = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic push_next(input string tag);
        if (m_tail) begin
            q_d.push_back(8'hFF); q_c.push_back(1'b0); q_t.push_back({tag, "/R6"});
        end else if (m_crc_due) begin
            q_d.push_back(m_crc); q_c.push_back(1'b1); q_t.push_back({tag, "/R4/R5"});
            m_crc = 8'h00;
            m_crc_due = 1'b0;
            if (m_addr == 127) m_tail = 1'b1;
            else               m_addr++;
        end else begin
            q_d.push_back(model[m_addr]); q_c.push_back(1'b0); q_t.push_back({tag, "/R2"});
            m_crc = ref_crc(m_crc, model[m_addr]);
            if ((m_addr % 32) == 31) m_crc_due = 1'b1;
            else                     m_addr++;
        end
    endtask

    task automatic reqs(input int n, input int gap, input string tag, input bit expect_out);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req = 1'b1;
            if (expect_out) push_next(tag);
            @(negedge clk);
            req = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic drain_check(input string tag);
        @(negedge clk);
        @(negedge clk);
        check(q_d.size() == 0, tag, "pending expectations", q_d.size(), 0);
        check(unexp == 0, tag, "unexpected outputs", unexp, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(crc_valid == 1'b0, "R1", "crc_valid after reset", crc_valid, 0);

        // R8: requests before any start
        reqs(3, 0, "R8", 1'b0);
        drain_check("R8");

        // R9: program most of the array, leave the tail of page 3 blank
        for (int a = 0; a < 110; a++) prog(a, 8'((a * 37 + 11) ^ (a >> 2)));
        prog(3, 8'h0F);
        prog(70, 8'hF0);

        // full sweep from address 0, back to back, into the tail
        do_start(0);
        reqs(4 * 33 + 3, 0, "R3", 1'b1);
        drain_check("R5");

        // R9: unprogrammed bytes read 0xFF; ANDed bytes from sweep above
        check(model[120] == 8'hFF, "R9", "model blank byte", model[120], 8'hFF);

        // mid-page start, spaced requests, then abort
        do_start(45);
        reqs(20, 1, "R4", 1'b1);
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        check(out_valid == 1'b0, "R7", "out_valid after bus_rst", out_valid, 0);
        reqs(4, 0, "R7", 1'b0);
        drain_check("R7");

        // start on the last byte: data, final CRC, then ones
        do_start(127);
        reqs(5, 0, "R6", 1'b1);
        drain_check("R6");

        // start on a page's last byte, crossing into next page
        do_start(31);
        reqs(36, 2, "R5", 1'b1);
        drain_check("R5");

        // abort during the CRC slot of a page
        do_start(62);
        reqs(2, 0, "R3", 1'b1);
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        reqs(2, 0, "R7", 1'b0);
        drain_check("R7");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule